// File: doc/BRIEF.md
# Extended Twelve-Register Bank File

This block holds the inner bank registers of an enhanced scanline-style cartridge memory controller. The CPU writes a bank index and control bits to a select register, then writes a bank number to a data register. The block turns its register contents into one 8-bit PRG bank number for each of the four 8 KiB CPU windows ($8000, $A000, $C000, $E000). It also gives a 1 KiB CHR bank number for each of the eight PPU windows ($0000 to $1C00 in 1 KiB steps). A separate mirroring register holds the two-bit nametable arrangement.

An extended-mode input grows the file from eight to twelve registers. In extended mode the two PRG windows that are normally fixed become selectable, and each 2 KiB CHR bank splits into two independent 1 KiB banks. With the input low, the block behaves as the standard eight-register controller. The IRQ counter and any outer bank composition sit outside this block.

Top module: `xbank_file`

## Requirements
- R1: A write responds only when (address AND $E003) equals $8000 (select), $8001 (data) or $A000 (mirroring). Every other address, including $9FFF, $8002, $A001, $C000 and $E001, changes no output.
- R2: The select register stores the full written byte. Bit 6 is the PRG swap flag, bit 7 is the CHR swap flag, and the register index is bits 3:0 in extended mode and bits 2:0 otherwise (so in standard mode an index of $8 writes register 0).
- R3: A data write stores all 8 bits into the register named by the current index. In extended mode, indices 12 to 15 store nothing.
- R4: After reset, the select register is $00, the mirroring register is 0, and registers 0 to 11 hold $00,$02,$04,$05,$06,$07,$00,$01,$FE,$FF,$FF,$FF.
- R5: Standard-mode PRG windows: $A000 takes register 7 and $E000 takes $FF. With the PRG swap flag clear, $8000 takes register 6 and $C000 takes $FE. With the flag set, those two are exchanged.
- R6: Extended-mode PRG windows: $A000 takes register 7 and $E000 takes register 9. With the PRG swap flag clear, $8000 takes register 6 and $C000 takes register 8. With the flag set, those two are exchanged.
- R7: Standard-mode CHR, swap flag clear: the windows at $0000/$0400 take register 0 with bit 0 forced to 0 and then to 1. The windows at $0800/$0C00 do the same with register 1. The windows at $1000..$1C00 take registers 2..5.
- R8: Extended-mode CHR, swap flag clear: the windows at $0000..$1C00 take registers 0, 10, 1, 11, 2, 3, 4, 5 in that order.
- R9: With the CHR swap flag set, the bank for the window at PPU address A is the one that A XOR $1000 would have with the flag clear. This holds in both modes.
- R10: A mirroring write stores data bits 1:0 (0 vertical, 1 horizontal), and the mirroring output shows them after the write.
- R11: The extended-mode input only changes the mapping. Registers 8 to 11 keep their contents while the input is low and show again when it returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_data | input | 8 | CPU write data |
| ext_mode | input | 1 | 1 selects twelve-register extended mode |
| prg_bank | output | 4x8 | PRG bank per 8 KiB window, index 0 is $8000 |
| chr_bank | output | 8x8 | CHR bank per 1 KiB window, index 0 is PPU $0000 |
| mirror_sel | output | 2 | Nametable mirroring code |

## Verification
The hardest case is the index-folding behaviour. The select byte has to carry index values 8 to 15 while the mode input is at each level, and only a sweep in both modes tells the standard-mode alias to register 0..7 apart from the extended-mode stores and drops. The bench writes every one of the sixteen indices in both modes with a distinct value. After each write it compares all twelve windows under all four combinations of the two swap flags. The retention of registers 8 to 11 can only be seen by hiding them with the mode input low and then showing them again.

// File: rtl/xbf_pkg.sv
package xbf_pkg;
    localparam int BANK_W   = 8;
    localparam int NUM_REGS = 12;
    localparam int STD_REGS = 8;
    localparam int PRG_WIN  = 4;
    localparam int CHR_WIN  = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef logic [BANK_W-1:0] bank_t;
    typedef bank_t [NUM_REGS-1:0] regs_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_DATA = 2'd2,
        ACC_MIRR = 2'd3
    } access_e;

    typedef struct packed {
        bank_t       sel;
        logic [1:0]  mirr;
        regs_t       regs;
    } state_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r[0]  = 8'h00; r[1]  = 8'h02; r[2]  = 8'h04; r[3]  = 8'h05;
        r[4]  = 8'h06; r[5]  = 8'h07; r[6]  = 8'h00; r[7]  = 8'h01;
        r[8]  = 8'hFE; r[9]  = 8'hFF; r[10] = 8'hFF; r[11] = 8'hFF;
        return r;
    endfunction
endpackage

// File: rtl/xbf_decode.sv
module xbf_decode
    import xbf_pkg::*;
#(
    parameter logic [15:0] ADDR_MASK = 16'hE003,
    parameter logic [15:0] SEL_ADDR  = 16'h8000,
    parameter logic [15:0] DATA_ADDR = 16'h8001,
    parameter logic [15:0] MIRR_ADDR = 16'hA000
) (
    input  logic        wr_en,
    input  logic [15:0] cpu_addr,
    output access_e     acc
);
    logic [15:0] masked;

    always_comb begin
        masked = cpu_addr & ADDR_MASK;
        acc    = ACC_NONE;
        if (wr_en) begin
            if (masked == SEL_ADDR)       acc = ACC_SEL;
            else if (masked == DATA_ADDR) acc = ACC_DATA;
            else if (masked == MIRR_ADDR) acc = ACC_MIRR;
        end
    end
endmodule

// File: rtl/xbf_regs.sv
module xbf_regs
    import xbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  access_e    acc,
    input  bank_t      cpu_data,
    input  logic       ext_mode,
    output bank_t      sel_q_o,
    output logic [1:0] mirr_q_o,
    output regs_t      regs_q_o
);
    state_t state_d, state_q;
    logic [3:0] wr_idx;
    logic       idx_ok;

    always_comb begin
        state_d = state_q;
        wr_idx  = ext_mode ? state_q.sel[3:0] : {1'b0, state_q.sel[2:0]};
        idx_ok  = (32'(wr_idx) < NUM_REGS);
        unique case (acc)
            ACC_SEL:  state_d.sel = cpu_data;
            ACC_DATA: if (idx_ok) state_d.regs[wr_idx] = cpu_data;
            ACC_MIRR: state_d.mirr = cpu_data[1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.sel  <= '0;
            state_q.mirr <= '0;
            state_q.regs <= reset_regs();
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_q_o  = state_q.sel;
    assign mirr_q_o = state_q.mirr;
    assign regs_q_o = state_q.regs;

    assert_reset_vals_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q.sel == 8'h00 && state_q.mirr == 2'd0
                           && state_q.regs == reset_regs()));

    assert_no_touch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE) |=> $stable(state_q));

    assert_data_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA && idx_ok) |=> (state_q.regs[$past(wr_idx)] == $past(cpu_data)));

    assert_high_idx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA && !idx_ok) |=> $stable(state_q.regs));

    assert_mirr_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_MIRR) |=> (state_q.mirr == $past(cpu_data[1:0])));

    assert_sel_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_SEL) |=> (state_q.sel == $past(cpu_data)));
endmodule

// File: rtl/xbf_map.sv
module xbf_map
    import xbf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ext_mode,
    input  bank_t                     sel,
    input  regs_t                     regs,
    output bank_t [PRG_WIN-1:0]       prg_bank,
    output bank_t [CHR_WIN-1:0]       chr_bank
);
    localparam int HALF = CHR_WIN / 2;
    localparam int PAIR_SLOTS = 4;
    localparam int EXT_IDX [CHR_WIN] = '{0, 10, 1, 11, 2, 3, 4, 5};

    bank_t fix_lo, fix_hi;
    bank_t slot_std [CHR_WIN];
    bank_t slot_ext [CHR_WIN];
    bank_t slot     [CHR_WIN];

    always_comb begin
        fix_lo = ext_mode ? regs[8] : 8'hFE;
        fix_hi = ext_mode ? regs[9] : 8'hFF;
        prg_bank[0] = sel[6] ? fix_lo  : regs[6];
        prg_bank[1] = regs[7];
        prg_bank[2] = sel[6] ? regs[6] : fix_lo;
        prg_bank[3] = fix_hi;
    end

    for (genvar s = 0; s < CHR_WIN; s++) begin : g_slot
        if (s < PAIR_SLOTS) begin : g_pair
            assign slot_std[s] = {regs[s/2][BANK_W-1:1], 1'(s % 2)};
        end else begin : g_single
            assign slot_std[s] = regs[s-2];
        end
        assign slot_ext[s] = regs[EXT_IDX[s]];
        assign slot[s]     = ext_mode ? slot_ext[s] : slot_std[s];
    end

    for (genvar w = 0; w < CHR_WIN; w++) begin : g_win
        assign chr_bank[w] = sel[7] ? slot[w ^ HALF] : slot[w];
    end

    assert_top_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (prg_bank[3] == 8'hFF));

    assert_fixed_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (prg_bank[0] == 8'hFE || prg_bank[2] == 8'hFE));

    assert_chr_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !sel[7]) |-> (chr_bank[1] == {chr_bank[0][7:1], 1'b1}));

    assert_chr_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && sel[7]) |-> (chr_bank[5] == {chr_bank[4][7:1], 1'b1}));
endmodule

// File: rtl/xbank_file.sv
module xbank_file
    import xbf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [15:0]            cpu_addr,
    input  logic [7:0]             cpu_data,
    input  logic                   ext_mode,
    output logic [3:0][7:0]        prg_bank,
    output logic [7:0][7:0]        chr_bank,
    output logic [1:0]             mirror_sel
);
    access_e acc;
    bank_t   sel_q;
    regs_t   regs_q;

    xbf_decode u_decode (
        .wr_en    (wr_en),
        .cpu_addr (cpu_addr),
        .acc      (acc)
    );

    xbf_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .cpu_data (cpu_data),
        .ext_mode (ext_mode),
        .sel_q_o  (sel_q),
        .mirr_q_o (mirror_sel),
        .regs_q_o (regs_q)
    );

    xbf_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (ext_mode),
        .sel      (sel_q),
        .regs     (regs_q),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );
endmodule

// File: tb/xbank_file_test.sv
module xbank_file_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic ext_mode = 1'b0;
    logic [3:0][7:0] prg_bank;
    logic [7:0][7:0] chr_bank;
    logic [1:0] mirror_sel;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_regs [12];
    logic [7:0] m_sel;
    logic [1:0] m_mirr;

    always #5 clk = ~clk;

    xbank_file uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_prg(input int w);
        logic [7:0] lo = ext_mode ? m_regs[8] : 8'hFE;
        logic [7:0] hi = ext_mode ? m_regs[9] : 8'hFF;
        case (w)
            0: return m_sel[6] ? lo : m_regs[6];
            1: return m_regs[7];
            2: return m_sel[6] ? m_regs[6] : lo;
            default: return hi;
        endcase
    endfunction

    function automatic logic [7:0] exp_chr(input int w);
        int s = m_sel[7] ? (w ^ 4) : w;
        int ext_tab [8] = '{0, 10, 1, 11, 2, 3, 4, 5};
        if (ext_mode) return m_regs[ext_tab[s]];
        if (s < 4) return {m_regs[s/2][7:1], s[0]};
        return m_regs[s-2];
    endfunction

    task automatic check_all(input string ctx);
        for (int w = 0; w < 4; w++)
            chk($sformatf("%s %s prg%0d", ctx, ext_mode ? "R6" : "R5", w),
                int'(prg_bank[w]), int'(exp_prg(w)));
        for (int w = 0; w < 8; w++)
            chk($sformatf("%s %s chr%0d", ctx,
                    m_sel[7] ? "R9" : (ext_mode ? "R8" : "R7"), w),
                int'(chr_bank[w]), int'(exp_chr(w)));
        chk($sformatf("%s R10 mirror", ctx), int'(mirror_sel), int'(m_mirr));
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (((a & 16'hE003) == 16'h8000)) m_sel = d;
        else if ((a & 16'hE003) == 16'h8001) begin
            int idx = ext_mode ? int'(m_sel[3:0]) : int'(m_sel[2:0]);
            if (idx < 12) m_regs[idx] = d;
        end else if ((a & 16'hE003) == 16'hA000) m_mirr = d[1:0];
    endtask

    task automatic set_ext(input logic e);
        @(negedge clk);
        ext_mode = e;
        #1;
    endtask

    initial begin
        logic [7:0] rv [12] = '{8'h00, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07,
                                8'h00, 8'h01, 8'hFE, 8'hFF, 8'hFF, 8'hFF};
        logic [15:0] dead [12] = '{16'h9FFF, 16'h8002, 16'h8003, 16'hA001,
                                   16'hA002, 16'hBFFF, 16'hC000, 16'hC001,
                                   16'hE000, 16'hE001, 16'h6000, 16'h0001};
        for (int i = 0; i < 12; i++) m_regs[i] = rv[i];
        m_sel = 8'h00; m_mirr = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R4 reset std");
        set_ext(1'b1);
        check_all("R4 reset ext");

        // R2/R3 sweep of every index in both modes, all swap-flag combos
        for (int e = 0; e < 2; e++) begin
            set_ext(e[0]);
            for (int idx = 0; idx < 16; idx++) begin
                bus_wr(16'h8000, 8'(idx));
                bus_wr(16'h8001, 8'(idx * 37 + 11 + e * 128));
                for (int f = 0; f < 4; f++) begin
                    bus_wr(16'h8000, 8'(idx | (f << 6)));
                    check_all(e ? "R3 ext index" : "R2 std index");
                end
            end
        end

        // R1 addresses that must not respond
        for (int i = 0; i < 12; i++) begin
            bus_wr(dead[i], 8'h5A);
            check_all("R1 ignored addr");
        end
        // R1 mirrored images of the responding addresses
        bus_wr(16'h9FFC, 8'h47);
        bus_wr(16'h9FFD, 8'h3C);
        check_all("R1 mirrored data");
        bus_wr(16'hBFFC, 8'hFD);
        check_all("R1 mirrored mirror");

        // R10 mirroring codes
        for (int v = 0; v < 4; v++) begin
            bus_wr(16'hA000, 8'(v | 8'hA4));
            chk("R10 mirror code", int'(mirror_sel), v);
        end

        // R11 registers 8-11 kept across mode toggle
        bus_wr(16'h8000, 8'h08); bus_wr(16'h8001, 8'h81);
        bus_wr(16'h8000, 8'h09); bus_wr(16'h8001, 8'h92);
        bus_wr(16'h8000, 8'h0A); bus_wr(16'h8001, 8'hA3);
        bus_wr(16'h8000, 8'h0B); bus_wr(16'h8001, 8'hB4);
        bus_wr(16'h8000, 8'h00);
        set_ext(1'b0);
        check_all("R11 hidden");
        set_ext(1'b1);
        check_all("R11 restored");
        chk("R11 reg9 at E000", int'(prg_bank[3]), 8'h92);
        chk("R11 reg10 at 0400", int'(chr_bank[1]), 8'hA3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule